// File: doc/BRIEF.md
# Shared 4x4/8x8 Two-Dimensional Integer Transform Engine

This block computes the separable two-dimensional integer transform used by a block-based video coder. One arithmetic datapath serves four kinds of work, chosen per block: an 8x8 forward transform, an 8x8 inverse transform, or a pair of independent 4x4 blocks, forward or inverse, handled side by side. Samples enter one row of eight lanes per beat and coefficients leave one row per beat. Both streams use a valid/ready handshake.

The first dimension runs on each row as it arrives. The second dimension adds each row's share into a bank of per-coefficient accumulators, so the design needs no transpose buffer. In pair mode the coefficient matrix is block-diagonal. Lanes 0-3 carry block A, lanes 4-7 carry block B, and the two blocks never mix. All coefficients are small integers, applied with shifts and adds. Scaling back to unit gain is left to the quantiser that follows.

Top module: `xf_shared_top`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: 8x8 forward mode (in_size4_i=0, in_inv_i=0) takes eight input beats, row a in beat a with column b on lane b. It produces Y = F·X·Fᵀ. The first four columns of F, row by row, are: {8,8,8,8}, {12,10,6,3}, {8,4,-4,-8}, {10,-3,-12,-6}, {8,-8,-8,8}, {6,-12,3,10}, {4,-8,8,-4}, {3,-6,10,-12}. Columns 4..7 mirror columns 3..0: the sign is kept on even rows and negated on odd rows.
- R3: 8x8 inverse mode (in_size4_i=0, in_inv_i=1) produces Y = Fᵀ·X·F.
- R4: Pair forward mode (in_size4_i=1, in_inv_i=0) takes four beats and forms Y = C·X·Cᵀ for each block independently. C is {1,1,1,1}, {2,1,-1,-2}, {1,-1,-1,1}, {1,-2,2,-1}.
- R5: Pair inverse mode (in_size4_i=1, in_inv_i=1) forms Y = D·X·Dᵀ for each block. D is {2,2,2,1}, {2,1,-2,-2}, {2,-1,-2,2}, {2,-2,2,-1}.
- R6: Size and direction are taken on the first beat of a block and ignored on its later beats. Consecutive blocks may use different modes with no idle beat between them.
- R7: Output rows appear in order 0..n-1, with n = 8 (8x8) or 4 (pair). Each beat echoes the block's mode. out_last_o is 1 on row n-1 only. out_tag_o is the block's sequence number modulo 2^TAG_W, starting at 0.
- R8: Results are exact, with no wrap, for all 9-bit signed inputs, including the extreme values -256 and 255.
- R9: While out_valid_o=1 and out_ready_i=0, the output data and tag hold steady and no row is lost.
- R10: With out_ready_i held at 1 and a run of blocks of the same size, in_ready_o stays 1: one row is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input row valid |
| in_ready_o | output | 1 | Input row accepted |
| in_data_i | input | 8*DATA_W | Eight signed samples, lane l at bits l*DATA_W |
| in_size4_i | input | 1 | 1 = pair of 4x4 blocks, 0 = one 8x8 block |
| in_inv_i | input | 1 | 1 = inverse, 0 = forward |
| out_valid_o | output | 1 | Output row valid |
| out_ready_i | input | 1 | Output row taken |
| out_data_o | output | 8*(DATA_W+14) | Eight signed coefficients, lane l at bits l*(DATA_W+14) |
| out_tag_o | output | TAG_W | Block sequence number |
| out_size4_o | output | 1 | Mode echo: pair size |
| out_inv_o | output | 1 | Mode echo: direction |
| out_last_o | output | 1 | Final row of the block |

## Verification
The hardest case to reach is a block whose last row is ready to enter the accumulator while the output bank still holds rows of the previous block, because the output is stalled or because a 4x4 pair follows an 8x8 block. The stimulus streams blocks with no gaps and cycles the modes every block, then applies random stalls on out_ready_i. This forces a last row to wait, and forces a new bank load in the same cycle the previous block's final row leaves. Blocks filled with all 255, all -256 and alternating extremes drive the widest sums.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int XF_N = 8;

  typedef logic signed [4:0] coef_t;

  typedef struct packed {
    logic size4;
    logic inv;
  } xf_mode_t;

  // left half of the 8x8 forward matrix
  function automatic coef_t f8_half(input logic [2:0] i, input logic [1:0] k);
    int r [4];
    case (i)
      3'd0: r = '{8, 8, 8, 8};
      3'd1: r = '{12, 10, 6, 3};
      3'd2: r = '{8, 4, -4, -8};
      3'd3: r = '{10, -3, -12, -6};
      3'd4: r = '{8, -8, -8, 8};
      3'd5: r = '{6, -12, 3, 10};
      3'd6: r = '{4, -8, 8, -4};
      default: r = '{3, -6, 10, -12};
    endcase
    return coef_t'(r[k]);
  endfunction

  function automatic coef_t f8(input logic [2:0] i, input logic [2:0] k);
    coef_t v;
    if (!k[2]) return f8_half(i, k[1:0]);
    v = f8_half(i, ~k[1:0]);
    return i[0] ? coef_t'(-v) : v;
  endfunction

  function automatic coef_t c4(input logic inv, input logic [1:0] i, input logic [1:0] k);
    int r [4];
    if (!inv) begin
      case (i)
        2'd0: r = '{1, 1, 1, 1};
        2'd1: r = '{2, 1, -1, -2};
        2'd2: r = '{1, -1, -1, 1};
        default: r = '{1, -2, 2, -1};
      endcase
    end else begin
      case (i)
        2'd0: r = '{2, 2, 2, 1};
        2'd1: r = '{2, 1, -2, -2};
        2'd2: r = '{2, -1, -2, 2};
        default: r = '{2, -2, 2, -1};
      endcase
    end
    return coef_t'(r[k]);
  endfunction

  // block-diagonal in pair mode, transposed for the 8x8 inverse
  function automatic coef_t coef(input xf_mode_t m, input logic [2:0] i, input logic [2:0] k);
    if (m.size4) begin
      if (i[2] != k[2]) return '0;
      return c4(m.inv, i[1:0], k[1:0]);
    end
    return m.inv ? f8(k, i) : f8(i, k);
  endfunction

  // multiplier-free product by a small constant
  function automatic logic signed [31:0] cmul(input logic signed [31:0] x, input coef_t c);
    logic signed [31:0] p;
    logic [4:0] m;
    m = c[4] ? 5'(-c) : 5'(c);
    case (m)
      5'd1:  p = x;
      5'd2:  p = x <<< 1;
      5'd3:  p = (x <<< 1) + x;
      5'd4:  p = x <<< 2;
      5'd6:  p = (x <<< 2) + (x <<< 1);
      5'd8:  p = x <<< 3;
      5'd10: p = (x <<< 3) + (x <<< 1);
      5'd12: p = (x <<< 3) + (x <<< 2);
      default: p = '0;
    endcase
    return c[4] ? -p : p;
  endfunction
endpackage

// File: rtl/xf_row_pass.sv
module xf_row_pass
  import xf_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ROW_W  = DATA_W + 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  xf_mode_t                mode_i,
  input  logic [XF_N*DATA_W-1:0]  x_i,
  output logic [XF_N*ROW_W-1:0]   r_o
);
  logic signed [DATA_W-1:0] x_s [XF_N];

  for (genvar k = 0; k < XF_N; k++) begin : g_unpack
    assign x_s[k] = x_i[k*DATA_W +: DATA_W];
  end

  for (genvar j = 0; j < XF_N; j++) begin : g_lane
    logic signed [31:0]      sum_w;
    logic signed [ROW_W-1:0] r_q;

    always_comb begin
      sum_w = '0;
      for (int k = 0; k < XF_N; k++)
        sum_w = sum_w + cmul(32'(x_s[k]), coef(mode_i, 3'(j), 3'(k)));
    end

    always_ff @(posedge clk_i) begin
      if (en_i) r_q <= sum_w[ROW_W-1:0];
    end

    assign r_o[j*ROW_W +: ROW_W] = r_q;

    assert_row_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |-> (sum_w[31:ROW_W-1] == '0 || sum_w[31:ROW_W-1] == '1));
  end
endmodule

// File: rtl/xf_col_accum.sv
module xf_col_accum
  import xf_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int ACC_W = ROW_W + 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   take_i,
  input  logic                   last_i,
  input  logic [2:0]             row_idx_i,
  input  xf_mode_t               mode_i,
  input  logic [XF_N*ROW_W-1:0]  r_i,
  input  logic [2:0]             rd_row_i,
  output logic [XF_N*ACC_W-1:0]  rd_data_o
);
  logic signed [ROW_W-1:0] r_s [XF_N];
  logic signed [ACC_W-1:0] bank_w [XF_N][XF_N];
  logic first;

  assign first = (row_idx_i == 3'd0);

  for (genvar k = 0; k < XF_N; k++) begin : g_unpack
    assign r_s[k] = r_i[k*ROW_W +: ROW_W];
  end

  for (genvar i = 0; i < XF_N; i++) begin : g_i
    for (genvar j = 0; j < XF_N; j++) begin : g_j
      logic signed [31:0]      sum_w;
      logic signed [ACC_W-1:0] acc_q;
      logic signed [ACC_W-1:0] bank_q;

      // column pass: add this row's contribution to coefficient (i,j)
      always_comb begin
        sum_w = cmul(32'(r_s[j]), coef(mode_i, 3'(i), row_idx_i));
        if (!first) sum_w = sum_w + 32'(acc_q);
      end

      always_ff @(posedge clk_i) begin
        if (take_i) begin
          acc_q <= sum_w[ACC_W-1:0];
          if (last_i) bank_q <= sum_w[ACC_W-1:0];
        end
      end

      assign bank_w[i][j] = bank_q;

      assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |-> (sum_w[31:ACC_W-1] == '0 || sum_w[31:ACC_W-1] == '1));
    end
  end

  for (genvar j = 0; j < XF_N; j++) begin : g_rd
    assign rd_data_o[j*ACC_W +: ACC_W] = bank_w[rd_row_i][j];
  end
endmodule

// File: rtl/xf_shared_top.sv
module xf_shared_top
  import xf_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int TAG_W  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic [8*DATA_W-1:0]           in_data_i,
  input  logic                          in_size4_i,
  input  logic                          in_inv_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [8*(DATA_W+14)-1:0]      out_data_o,
  output logic [TAG_W-1:0]              out_tag_o,
  output logic                          out_size4_o,
  output logic                          out_inv_o,
  output logic                          out_last_o
);
  localparam int ROW_W = DATA_W + 7;
  localparam int ACC_W = ROW_W + 7;

  // input sequencing
  logic [2:0]       in_row_q;
  xf_mode_t         blk_mode_q, cur_mode;
  logic [TAG_W-1:0] tag_cnt_q;
  logic             in_fire, in_last;

  assign cur_mode = (in_row_q == 3'd0) ? xf_mode_t'{size4: in_size4_i, inv: in_inv_i} : blk_mode_q;
  assign in_last  = (in_row_q == (cur_mode.size4 ? 3'd3 : 3'd7));
  assign in_fire  = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_row_q   <= '0;
      blk_mode_q <= '0;
      tag_cnt_q  <= '0;
    end else if (in_fire) begin
      in_row_q   <= in_last ? 3'd0 : in_row_q + 3'd1;
      blk_mode_q <= cur_mode;
      if (in_last) tag_cnt_q <= tag_cnt_q + 1'b1;
    end
  end

  // row stage
  logic             s1_v, s1_last, s2_take;
  logic [2:0]       s1_row;
  xf_mode_t         s1_mode;
  logic [TAG_W-1:0] s1_tag;
  logic [8*ROW_W-1:0] r_w;

  xf_row_pass #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_row (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (in_fire), .mode_i (cur_mode),
    .x_i (in_data_i), .r_o (r_w)
  );

  // output bank control
  logic             ob_v, ob_free, out_fire, ob_at_last;
  logic [2:0]       ob_row;
  xf_mode_t         ob_mode;
  logic [TAG_W-1:0] ob_tag;

  assign ob_at_last = (ob_row == (ob_mode.size4 ? 3'd3 : 3'd7));
  assign out_fire   = ob_v && out_ready_i;
  assign ob_free    = !ob_v || (out_ready_i && ob_at_last);
  // a last row may only land once the bank is free
  assign s2_take    = s1_v && (!s1_last || ob_free);
  assign in_ready_o = !s1_v || s2_take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s1_last <= 1'b0;
      s1_row  <= '0;
      s1_mode <= '0;
      s1_tag  <= '0;
    end else if (in_fire) begin
      s1_v    <= 1'b1;
      s1_last <= in_last;
      s1_row  <= in_row_q;
      s1_mode <= cur_mode;
      s1_tag  <= tag_cnt_q;
    end else if (s2_take) begin
      s1_v    <= 1'b0;
    end
  end

  xf_col_accum #(.ROW_W(ROW_W), .ACC_W(ACC_W)) u_col (
    .clk_i (clk_i), .rst_ni (rst_ni), .take_i (s2_take), .last_i (s1_last),
    .row_idx_i (s1_row), .mode_i (s1_mode), .r_i (r_w),
    .rd_row_i (ob_row), .rd_data_o (out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ob_v    <= 1'b0;
      ob_row  <= '0;
      ob_mode <= '0;
      ob_tag  <= '0;
    end else if (s2_take && s1_last) begin
      ob_v    <= 1'b1;
      ob_row  <= '0;
      ob_mode <= s1_mode;
      ob_tag  <= s1_tag;
    end else if (out_fire) begin
      if (ob_at_last) ob_v <= 1'b0;
      else            ob_row <= ob_row + 3'd1;
    end
  end

  assign out_valid_o = ob_v;
  assign out_tag_o   = ob_tag;
  assign out_size4_o = ob_mode.size4;
  assign out_inv_o   = ob_mode.inv;
  assign out_last_o  = ob_v && ob_at_last;

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_tag_o));

  assert_tag_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> !out_valid_o || (out_tag_o == $past(out_tag_o) + 1'b1));

  assert_mode_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_v && !s1_last |=> s1_mode == $past(s1_mode));

  assert_bank_safe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_take && s1_last && out_valid_o |-> out_ready_i && out_last_o);
endmodule

// File: tb/tb_xf_shared_top.sv
module tb_xf_shared_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 9;
  localparam int TAG_W  = 4;
  localparam int ACC_W  = DATA_W + 14;
  localparam int NB     = 30;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_size4_i = 1'b0, in_inv_i = 1'b0, out_ready_i = 1'b0;
  logic [8*DATA_W-1:0] in_data_i = '0;
  logic in_ready_o, out_valid_o, out_size4_o, out_inv_o, out_last_o;
  logic [8*ACC_W-1:0] out_data_o;
  logic [TAG_W-1:0] out_tag_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xf_shared_top #(.DATA_W(DATA_W), .TAG_W(TAG_W)) dut (.*);

  int n_chk = 0, n_err = 0, stall_cnt = 0, cyc = 0;
  bit go = 0, done = 0;
  int f8 [8][8], c4f [4][4], c4i [4][4];
  int xs [NB][8][8], ye [NB][8][8];
  bit sz [NB], iv [NB];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic int mc(bit s4, bit inv, int i, int k);
    if (s4) return inv ? c4i[i][k] : c4f[i][k];
    return inv ? f8[k][i] : f8[i][k];
  endfunction

  function automatic string req_of(int b);
    if (b == 2 || b == 3 || b == 6 || b == 7 || b == 10 || b == 14) return "R8";
    if (!sz[b]) return iv[b] ? "R3" : "R2";
    return iv[b] ? "R5" : "R4";
  endfunction

  initial begin
    f8 = '{'{8,8,8,8,8,8,8,8}, '{12,10,6,3,-3,-6,-10,-12}, '{8,4,-4,-8,-8,-4,4,8},
           '{10,-3,-12,-6,6,12,3,-10}, '{8,-8,-8,8,8,-8,-8,8}, '{6,-12,3,10,-10,-3,12,-6},
           '{4,-8,8,-4,-4,8,-8,4}, '{3,-6,10,-12,12,-10,6,-3}};
    c4f = '{'{1,1,1,1}, '{2,1,-1,-2}, '{1,-1,-1,1}, '{1,-2,2,-1}};
    c4i = '{'{2,2,2,1}, '{2,1,-2,-2}, '{2,-1,-2,2}, '{2,-2,2,-1}};
    for (int b = 0; b < NB; b++) begin
      if (b < 8)       begin sz[b] = 0; iv[b] = (b >= 4); end
      else if (b < 16) begin sz[b] = 1; iv[b] = (b >= 12); end
      else             begin sz[b] = b[0]; iv[b] = b[1]; end
      for (int r = 0; r < 8; r++)
        for (int l = 0; l < 8; l++) begin
          int v;
          v = $urandom_range(0, 511) - 256;
          if (b == 2) v = 255;
          if (b == 6) v = -256;
          if (b == 3 || b == 7) v = ((r + l) % 2 == 0) ? 255 : -256;
          if (b == 10 || b == 14) v = (l < 4) ? 255 : -256;
          xs[b][r][l] = v;
        end
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          int s;
          s = 0;
          if (!sz[b]) begin
            for (int a = 0; a < 8; a++)
              for (int c = 0; c < 8; c++)
                s += mc(0, iv[b], i, a) * xs[b][a][c] * mc(0, iv[b], j, c);
          end else if (i < 4) begin
            for (int a = 0; a < 4; a++)
              for (int c = 0; c < 4; c++)
                s += mc(1, iv[b], i, a) * xs[b][a][4*(j/4) + c] * mc(1, iv[b], j % 4, c);
          end
          ye[b][i][j] = s;
        end
    end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1", "out_valid after reset", out_valid_o, 0);
    chk(in_ready_o == 1'b1, "R1", "in_ready after reset", in_ready_o, 1);
    go = 1;
    wait (done);
    chk(stall_cnt == 0, "R10", "input stalls in same-size run", stall_cnt, 0);
    report();
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      chk(0, "watchdog", "run did not finish", cyc, 20000);
      report();
    end
  end

  // producer: gap-free stream; later-beat mode inputs are scrambled (R6)
  initial begin
    wait (go);
    @(posedge clk_i); #1;
    for (int b = 0; b < NB; b++) begin
      for (int r = 0; r < (sz[b] ? 4 : 8); r++) begin
        bit acc;
        in_valid_i = 1'b1;
        in_size4_i = (r == 0) ? sz[b] : ~sz[b];
        in_inv_i   = (r == 0) ? iv[b] : ~iv[b];
        for (int l = 0; l < 8; l++) in_data_i[l*DATA_W +: DATA_W] = DATA_W'(xs[b][r][l]);
        do begin
          @(negedge clk_i);
          acc = in_ready_o;
          if (b < 8 && !acc) stall_cnt++;
          @(posedge clk_i); #1;
        end while (!acc);
      end
    end
    in_valid_i = 1'b0;
  end

  // consumer: random stalls from block 16 on
  initial begin
    int ob, orow;
    bit held;
    logic [8*ACC_W-1:0] hd;
    logic [TAG_W-1:0] ht;
    ob = 0; orow = 0; held = 0; hd = '0; ht = '0;
    wait (go);
    while (ob < NB) begin
      @(posedge clk_i); #1;
      out_ready_i = (ob >= 16) ? ($urandom_range(0, 3) != 0) : 1'b1;
      @(negedge clk_i);
      if (held) begin
        chk(out_valid_o == 1'b1, "R9", "valid dropped under stall", out_valid_o, 1);
        chk(out_data_o == hd && out_tag_o == ht, "R9", "row changed under stall", out_tag_o, ht);
      end
      held = out_valid_o && !out_ready_i;
      hd = out_data_o; ht = out_tag_o;
      if (out_valid_o && out_ready_i) begin
        int bad_l;
        bad_l = -1;
        for (int l = 0; l < 8; l++)
          if (int'($signed(out_data_o[l*ACC_W +: ACC_W])) != ye[ob][orow][l] && bad_l < 0) bad_l = l;
        if (bad_l >= 0)
          chk(0, req_of(ob), $sformatf("block %0d row %0d lane %0d", ob, orow, bad_l),
              longint'($signed(out_data_o[bad_l*ACC_W +: ACC_W])), ye[ob][orow][bad_l]);
        else
          chk(1, req_of(ob), "row data", 0, 0);
        chk(out_tag_o == TAG_W'(ob), "R7", $sformatf("tag block %0d", ob), out_tag_o, ob % 16);
        chk(out_size4_o == sz[ob] && out_inv_o == iv[ob], "R6",
            $sformatf("mode echo block %0d", ob), {out_size4_o, out_inv_o}, {sz[ob], iv[ob]});
        chk(out_last_o == (orow == (sz[ob] ? 3 : 7)), "R7",
            $sformatf("last flag block %0d row %0d", ob, orow), out_last_o, orow == (sz[ob] ? 3 : 7));
        if (orow == (sz[ob] ? 3 : 7)) begin orow = 0; ob++; end
        else orow++;
      end
    end
    done = 1;
  end
endmodule